// File: doc/BRIEF.md
# Asynchronous Host Write Port Decoder

This block takes write cycles from an asynchronous 16-bit host bus and turns them into single-clock write strobes for the internal clock domain. The host marks a write with an active-low chip select and an active-low write strobe. A fast internal clock oversamples every host line through a synchronizer. A write is in progress while both strobes are low. The address, data and select line are copied on every internal clock of that active window. When either strobe goes high, the block commits the last copy it took.

Each completed write goes to one of two ports. With the select line low, it becomes a write on a register-file port that carries the word address and data. With the select line high, the address is ignored and the word is pushed into a transmit FIFO. A push that meets a full FIFO is dropped, and a sticky overflow flag records the loss until a clear input removes it.

Top module: `hostWritePort`

## Requirements
- R1: A write is committed only after both `csN` and `wrN` have been sampled low together. A cycle in which only one of the two strobes goes low produces no write on either port.
- R2: Every completed write produces exactly one pulse, one clock wide. The pulse is on `regWrEn` or `fifoPush` and is high in the clock cycle after the third rising clock edge that follows the first strobe rising.
- R3: The strobes may fall in either order and rise in either order. The write ends with whichever strobe rises first.
- R4: The committed address, data and select are the values that were on the bus at the last synchronized sample taken while both strobes were low. Earlier values from the same cycle are discarded.
- R5: When `fifoSel` is 0, the commit raises `regWrEn`. `regAddr` then equals the host word address and `regWdata` equals the host data.
- R6: When `fifoSel` is 1, the commit raises `fifoPush` with `fifoWdata` equal to the host data, and the address is ignored. `regWrEn` and `fifoPush` are never high together.
- R7: A FIFO commit that meets `fifoFull` = 1 gives no push and sets `fifoOverflow`. The flag then stays at 1 through later writes.
- R8: `ovfClear` = 1 clears `fifoOverflow` on the next clock edge, unless a dropped push occurs at that same edge.
- R9: While `rst` is high, `regWrEn`, `fifoPush` and `fifoOverflow` are 0. If both strobes are already low when reset is released, that cycle produces no write when it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| csN | input | 1 | Host chip select, active low, asynchronous |
| wrN | input | 1 | Host write strobe, active low, asynchronous |
| hostAddr | input | 7 | Host word address |
| hostData | input | 16 | Host write data |
| fifoSel | input | 1 | Steers the write to the FIFO when high; same timing as the address |
| fifoFull | input | 1 | Transmit FIFO cannot accept a word |
| ovfClear | input | 1 | Synchronous clear of the overflow flag |
| regWrEn | output | 1 | One-clock register-file write strobe |
| regAddr | output | 7 | Register-file word address |
| regWdata | output | 16 | Register-file write data |
| fifoPush | output | 1 | One-clock FIFO push strobe |
| fifoWdata | output | 16 | FIFO write word |
| fifoOverflow | output | 1 | Sticky flag for a dropped push |

## Verification
The host lines reach the control logic after two synchronizer flops, and the commit pulse is registered once more. A write therefore shows up in the cycle after the third rising edge that follows the first strobe rise. The overflow flag changes on the same edge as the dropped push, and a clear takes effect one edge after `ovfClear` is seen. The bench drives inputs on falling edges and samples on falling edges. Its reference model advances on every rising edge with the same two-sample delay, so expected and actual values are compared in the same cycle. The write task also counts falling edges after the strobe rise and requires the pulse on the third one only.

// File: rtl/hwpPkg.sv
`timescale 1ns/1ps
package hwpPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // copy bus sample into the hold registers
  } hwpStrobe_t;
endpackage

// File: rtl/hwpSync.sv
`timescale 1ns/1ps
module hwpSync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) stage[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/hwpData.sv
`timescale 1ns/1ps
module hwpData
  import hwpPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  hwpStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addrSync,
  input  logic [DATA_W-1:0] dataSync,
  input  logic              selSync,
  output logic [ADDR_W-1:0] latAddr,
  output logic [DATA_W-1:0] latData,
  output logic              latSel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latAddr <= '0;
      latData <= '0;
      latSel  <= 1'b0;
    end else if (strobe.capture) begin
      latAddr <= addrSync;
      latData <= dataSync;
      latSel  <= selSync;
    end
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.capture |=> $stable({latAddr, latData, latSel})); // R4
endmodule

// File: rtl/hwpCtrl.sv
`timescale 1ns/1ps
module hwpCtrl
  import hwpPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       csSync,
  input  logic       wrSync,
  input  logic       latSel,
  input  logic       fifoFull,
  input  logic       ovfClear,
  output hwpStrobe_t strobe,
  output logic       regWrEn,
  output logic       fifoPush,
  output logic       fifoOverflow
);
  logic active, prevActive, inCycle;
  logic startEvt, endEvt, dropEvt;

  always_comb begin
    active         = ~csSync & ~wrSync;
    startEvt       = active & ~prevActive;
    endEvt         = ~active & prevActive & inCycle;
    dropEvt        = endEvt & latSel & fifoFull;
    strobe.capture = active;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevActive   <= 1'b1;   // treat bus as busy: a cycle open at release is not armed
      inCycle      <= 1'b0;
      regWrEn      <= 1'b0;
      fifoPush     <= 1'b0;
      fifoOverflow <= 1'b0;
    end else begin
      prevActive <= active;
      if (startEvt)     inCycle <= 1'b1;
      else if (!active) inCycle <= 1'b0;
      regWrEn  <= endEvt & ~latSel;
      fifoPush <= endEvt & latSel & ~fifoFull;
      if (dropEvt)       fifoOverflow <= 1'b1;
      else if (ovfClear) fifoOverflow <= 1'b0;
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0({regWrEn, fifoPush})); // R6
  AST_REG_PULSE: assert property (@(posedge clk) disable iff (rst)
    regWrEn |=> !regWrEn); // R2
  AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (rst)
    fifoPush |=> !fifoPush); // R2
  AST_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (regWrEn || fifoPush) |-> $past(inCycle)); // R1
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
    fifoPush |-> !$past(fifoFull)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fifoOverflow && !ovfClear) |=> fifoOverflow); // R7
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ovfClear && !dropEvt) |=> !fifoOverflow); // R8
endmodule

// File: rtl/hostWritePort.sv
`timescale 1ns/1ps
module hostWritePort
  import hwpPkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostData,
  input  logic              fifoSel,
  input  logic              fifoFull,
  input  logic              ovfClear,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              fifoPush,
  output logic [DATA_W-1:0] fifoWdata,
  output logic              fifoOverflow
);
  localparam int BUS_W = ADDR_W + DATA_W + 3;

  logic [BUS_W-1:0]  busSync;
  logic              csSync, wrSync, selSync;
  logic [ADDR_W-1:0] addrSync, latAddr;
  logic [DATA_W-1:0] dataSync, latData;
  logic              latSel;
  hwpStrobe_t        strobe;

  hwpSync #(.W(BUS_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .d   ({csN, wrN, fifoSel, hostAddr, hostData}),
    .q   (busSync)
  );

  assign {csSync, wrSync, selSync, addrSync, dataSync} = busSync;

  hwpCtrl i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .csSync       (csSync),
    .wrSync       (wrSync),
    .latSel       (latSel),
    .fifoFull     (fifoFull),
    .ovfClear     (ovfClear),
    .strobe       (strobe),
    .regWrEn      (regWrEn),
    .fifoPush     (fifoPush),
    .fifoOverflow (fifoOverflow)
  );

  hwpData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_data (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .addrSync (addrSync),
    .dataSync (dataSync),
    .selSync  (selSync),
    .latAddr  (latAddr),
    .latData  (latData),
    .latSel   (latSel)
  );

  assign regAddr   = latAddr;
  assign regWdata  = latData;
  assign fifoWdata = latData;
endmodule

// File: tb/test_hostWritePort.sv
`timescale 1ns/1ps
module test_hostWritePort;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csN = 1'b1, wrN = 1'b1, fifoSel = 1'b0, fifoFull = 1'b0, ovfClear = 1'b0;
  logic [6:0]  hostAddr = '0;
  logic [15:0] hostData = '0;
  logic regWrEn, fifoPush, fifoOverflow;
  logic [6:0]  regAddr;
  logic [15:0] regWdata, fifoWdata;

  int checks = 0, errors = 0;
  int regCount = 0, pushCount = 0;
  int lastAddr = 0, lastData = 0, lastFifo = 0;
  bit started = 0, done = 0;

  always #2.5 clk = ~clk;

  hostWritePort i_hostWritePort (
    .clk(clk), .rst(rst), .csN(csN), .wrN(wrN), .hostAddr(hostAddr),
    .hostData(hostData), .fifoSel(fifoSel), .fifoFull(fifoFull),
    .ovfClear(ovfClear), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .fifoPush(fifoPush), .fifoWdata(fifoWdata),
    .fifoOverflow(fifoOverflow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: two-sample delay queue, then edge detection
  int qCs[$], qWr[$], qSel[$], qAddr[$], qData[$];
  bit mPrev = 1, mArmed = 0, mSel = 0;
  int mAddr = 0, mData = 0;
  bit expReg = 0, expPush = 0, expOvf = 0;

  always @(posedge clk) begin
    bit act, fin;
    if (qCs.size() == 2) begin
      act = (qCs[0] == 0) && (qWr[0] == 0);
      if (rst) begin
        expReg = 0; expPush = 0; expOvf = 0; mPrev = 1; mArmed = 0;
      end else begin
        fin = !act && mPrev && mArmed;
        expReg  = fin && !mSel;
        expPush = fin && mSel && !fifoFull;
        if (fin && mSel && fifoFull) expOvf = 1;
        else if (ovfClear) expOvf = 0;
        if (act) begin mSel = qSel[0]; mAddr = qAddr[0]; mData = qData[0]; end
        if (act && !mPrev) mArmed = 1;
        else if (!act) mArmed = 0;
        mPrev = act;
      end
      void'(qCs.pop_front()); void'(qWr.pop_front()); void'(qSel.pop_front());
      void'(qAddr.pop_front()); void'(qData.pop_front());
    end
    qCs.push_back(csN); qWr.push_back(wrN); qSel.push_back(fifoSel);
    qAddr.push_back(hostAddr); qData.push_back(hostData);
  end

  always @(negedge clk) begin
    if (started) begin
      check(regWrEn == expReg, "R2", "regWrEn", regWrEn, expReg);
      check(fifoPush == expPush, "R6", "fifoPush", fifoPush, expPush);
      check(fifoOverflow == expOvf, "R7", "fifoOverflow", fifoOverflow, expOvf);
      if (expReg) begin
        check(regAddr == mAddr[6:0], "R5", "regAddr", regAddr, mAddr);
        check(regWdata == mData[15:0], "R4", "regWdata", regWdata, mData);
      end
      if (expPush) check(fifoWdata == mData[15:0], "R6", "fifoWdata", fifoWdata, mData);
    end
    if (regWrEn)  begin regCount++;  lastAddr = regAddr; lastData = regWdata; end
    if (fifoPush) begin pushCount++; lastFifo = fifoWdata; end
  end

  // Decoy values first; the final values are driven 3 cycles before the rise
  task automatic doWrite(input bit csFirst, input bit csRisesFirst, input logic [6:0] a,
                         input logic [15:0] d, input bit sel, input int hold,
                         input bit expectPulse);
    @(negedge clk);
    hostAddr = ~a; hostData = ~d; fifoSel = sel;
    if (csFirst) csN = 0; else wrN = 0;
    @(negedge clk);
    csN = 0; wrN = 0;
    repeat (hold - 3) @(negedge clk);
    hostAddr = a; hostData = d;
    repeat (3) @(negedge clk);
    if (csRisesFirst) csN = 1; else wrN = 1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == 1) begin csN = 1; wrN = 1; end
      check((regWrEn | fifoPush) == (expectPulse && k == 3), "R2", "pulse timing",
            regWrEn | fifoPush, expectPulse && k == 3);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int rc, pc;
    repeat (3) @(negedge clk);
    started = 1;
    check(!regWrEn && !fifoPush && !fifoOverflow, "R9", "reset outputs",
          {regWrEn, fifoPush, fifoOverflow}, 0);
    rst = 0;
    repeat (3) @(negedge clk);

    // R5: register write, cs falls first, cs rises first
    rc = regCount;
    doWrite(1, 1, 7'h12, 16'hA5A5, 0, 5, 1);
    check(regCount == rc + 1, "R5", "reg write count", regCount, rc + 1);
    check(lastAddr == 7'h12 && lastData == 16'hA5A5, "R4", "committed word",
          lastData, 16'hA5A5);

    // R3: wr falls first and rises first
    rc = regCount;
    doWrite(0, 0, 7'h3C, 16'h1234, 0, 6, 1);
    check(regCount == rc + 1 && lastAddr == 7'h3C, "R3", "other order", lastAddr, 7'h3C);

    // R1: only one strobe low gives no write
    rc = regCount; pc = pushCount;
    @(negedge clk); csN = 0; repeat (6) @(negedge clk); csN = 1;
    repeat (6) @(negedge clk); wrN = 0; repeat (6) @(negedge clk); wrN = 1;
    repeat (6) @(negedge clk);
    check(regCount == rc && pushCount == pc, "R1", "single strobe", regCount, rc);

    // R6: FIFO write, address ignored
    rc = regCount; pc = pushCount;
    doWrite(1, 0, 7'h7F, 16'hBEEF, 1, 5, 1);
    check(pushCount == pc + 1 && regCount == rc, "R6", "fifo steer", pushCount, pc + 1);
    check(lastFifo == 16'hBEEF, "R6", "fifo word", lastFifo, 16'hBEEF);

    // R7: full FIFO drops the word, flag sticks
    pc = pushCount; fifoFull = 1;
    doWrite(0, 1, 7'h01, 16'hDEAD, 1, 4, 0);
    check(pushCount == pc && fifoOverflow == 1, "R7", "drop on full", fifoOverflow, 1);
    fifoFull = 0;
    doWrite(1, 1, 7'h02, 16'h5555, 1, 4, 1);
    check(fifoOverflow == 1, "R7", "flag sticky", fifoOverflow, 1);

    // R8: clear
    @(negedge clk); ovfClear = 1; @(negedge clk); ovfClear = 0;
    check(fifoOverflow == 0, "R8", "flag cleared", fifoOverflow, 0);

    // R9: strobes low across reset release
    rc = regCount; pc = pushCount;
    @(negedge clk); csN = 0; wrN = 0; rst = 1;
    repeat (4) @(negedge clk); rst = 0;
    repeat (5) @(negedge clk); csN = 1; wrN = 1;
    repeat (6) @(negedge clk);
    check(regCount == rc && pushCount == pc, "R9", "no write after reset", regCount, rc);
    doWrite(1, 1, 7'h55, 16'h0F0F, 0, 5, 1);
    check(lastAddr == 7'h55 && lastData == 16'h0F0F, "R5", "write after reset",
          lastData, 16'h0F0F);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule